// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer with 9-bit words. Its write side and its read side each run on their own clock, and the two clocks may also be tied together. Each side has two active-low enables. Four active-low status flags report the buffer state. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. Each side learns the other side's pointer through a two-stage synchroniser that carries Gray code.

The second write-enable pin has two possible roles, and the block samples it while reset is held to choose one. If the pin is high during reset, it acts as a plain second write enable. If the pin is low during reset, it becomes a load strobe. While the strobe is low, write-clock cycles store the input word into the threshold registers instead of the buffer. Read-clock cycles then put the threshold values on the output instead of popping a word. The two thresholds are always visited in a fixed alternating order, almost-empty first.

The output word is registered. An active-low output enable gates it onto a tri-state bus.

Top module: `dcfifo_pflag`

## Requirements
- R1: When `we1_n`=0, `we2_ld`=1 and `full_n`=1 at a rising write-clock edge, `d_in` is stored. Stored words leave in the order they were written.
- R2: When `re1_n`=0, `re2_n`=0 and `empty_n`=1 at a rising read-clock edge, and the load strobe is not active, the oldest word is loaded into the output register. In every other cycle the output register holds its value.
- R3: `full_n` is 0 exactly when the write-side occupancy equals DEPTH (16 by default). Write attempts while full change nothing.
- R4: `empty_n` is 0 exactly when the read-side occupancy is 0. Read attempts while empty change nothing.
- R5: Write-side occupancy is the writes so far minus the reads seen two write-clock edges earlier. Read-side occupancy is the writes seen two read-clock edges earlier minus the reads so far.
- R6: `aempty_n` is 0 when the read-side occupancy is less than or equal to the almost-empty threshold.
- R7: `afull_n` is 0 when DEPTH minus the write-side occupancy is less than or equal to the almost-full threshold.
- R8: The value of `we2_ld` while `rst_n` is low selects the mode: 1 gives second-enable mode, 0 gives load mode. In second-enable mode, `we2_ld`=0 blocks writes and leaves the thresholds untouched.
- R9: In load mode, `we1_n`=0 with `we2_ld`=0 writes `d_in[4:0]` into one threshold register and stores no data. The first such write goes to almost-empty, the next to almost-full, and the order keeps alternating.
- R10: In load mode, `re1_n`=`re2_n`=0 with `we2_ld`=0 puts the next threshold, zero-extended, into the output register in the same alternating order. No word is popped.
- R11: Reset leaves the buffer empty. It sets both thresholds to 2, restarts both access orders at almost-empty, and clears the output register to 0.
- R12: With `oe_n`=1 the output bus is high impedance. With `oe_n`=0 it carries the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| d_in | input | 9 | Write data and threshold load value |
| we1_n | input | 1 | Primary write enable, active low |
| we2_ld | input | 1 | Second write enable (high active) or load strobe (low active), chosen at reset |
| re1_n | input | 1 | First read enable, active low |
| re2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| q_out | output | 9 | Tri-state read data |
| empty_n | output | 1 | Empty flag, read clock |
| full_n | output | 1 | Full flag, write clock |
| aempty_n | output | 1 | Almost-empty flag, read clock |
| afull_n | output | 1 | Almost-full flag, write clock |

## Verification
The hardest situation to reach is a buffer pinned at or near full while reads keep draining it. In that state the two-edge pointer lag decides whether a write attempt at the boundary is accepted. The stimulus alternates blocks of write-heavy and read-heavy traffic, so the occupancy sweeps repeatedly between both ends while both sides stay active. Load-mode traffic adds threshold writes and read-backs at random points in the stream, so threshold changes land while the flags are near their limits.

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int AW     = 4,
  parameter int W      = 9,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2
) (
  input  logic         wr_clk,
  input  logic         rd_clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  input  logic         we1_n,
  input  logic         we2_ld,
  input  logic         re1_n,
  input  logic         re2_n,
  input  logic         oe_n,
  output logic [W-1:0] q_out,
  output logic         empty_n,
  output logic         full_n,
  output logic         aempty_n,
  output logic         afull_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam logic [PW-1:0] FULLV = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic          ld_mode;
  logic [PW-1:0] wbin, wgray, rg1, rg2;
  logic [PW-1:0] rbin, rgray, wg1, wg2;
  logic [PW-1:0] ae_off, af_off;
  logic          wsel, rsel;
  logic [W-1:0]  q_reg;

  // mode follows the pin for as long as reset is held
  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) ld_mode <= ~we2_ld;

  wire           ld_act  = ld_mode & ~we2_ld;
  wire           wr_data = ~we1_n & we2_ld & full_n;
  wire           ofs_wr  = ~we1_n & ld_act;
  wire [PW-1:0]  wbin_nx = wbin + 1'b1;
  wire [PW-1:0]  wocc    = wbin - g2b(rg2);

  assign full_n  = (wocc != FULLV);
  assign afull_n = ~((FULLV - wocc) <= af_off);

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg1   <= '0;
      rg2   <= '0;
    end else begin
      rg1 <= rgray;
      rg2 <= rg1;
      if (wr_data) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end

  always_ff @(posedge wr_clk)
    if (wr_data) mem[wbin[AW-1:0]] <= d_in;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      ae_off <= PW'(AE_DEF);
      af_off <= PW'(AF_DEF);
      wsel   <= 1'b0;
    end else if (ofs_wr) begin
      if (wsel) af_off <= d_in[PW-1:0];
      else      ae_off <= d_in[PW-1:0];
      wsel <= ~wsel;
    end

  wire           rd_req  = ~re1_n & ~re2_n;
  wire           rd_data = rd_req & ~ld_act & empty_n;
  wire           ofs_rd  = rd_req & ld_act;
  wire [PW-1:0]  rbin_nx = rbin + 1'b1;
  wire [PW-1:0]  rocc    = g2b(wg2) - rbin;

  assign empty_n  = (rocc != '0);
  assign aempty_n = ~(rocc <= ae_off);

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg1   <= '0;
      wg2   <= '0;
      rsel  <= 1'b0;
      q_reg <= '0;
    end else begin
      wg1 <= wgray;
      wg2 <= wg1;
      if (rd_data) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
        q_reg <= mem[rbin[AW-1:0]];
      end else if (ofs_rd) begin
        q_reg <= W'(rsel ? af_off : ae_off);
        rsel  <= ~rsel;
      end
    end

  assign q_out = oe_n ? {W{1'bz}} : q_reg;

  a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wocc <= FULLV);
  a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rocc <= FULLV);
  a_r5_wgray_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  a_r5_rgray_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  a_r6_empty_is_low: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
  a_r7_full_is_high: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n);
  a_r2_q_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_req |=> $stable(q_reg));
  a_r9_ofs_no_push: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ofs_wr |=> $stable(wbin));
endmodule

// File: tb/tb_dcfifo_pflag.sv
`timescale 1ns/1ps
module tb_dcfifo_pflag;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, we1_n, we2_ld, re1_n, re2_n, oe_n, tb_en;
  logic [8:0] d_in, tb_val;
  wire  [8:0] qbus;
  wire        empty_n, full_n, aempty_n, afull_n;

  assign qbus = tb_en ? tb_val : 9'bz;

  dcfifo_pflag dut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .d_in(d_in),
    .we1_n(we1_n), .we2_ld(we2_ld), .re1_n(re1_n), .re2_n(re2_n),
    .oe_n(oe_n), .q_out(qbus), .empty_n(empty_n), .full_n(full_n),
    .aempty_n(aempty_n), .afull_n(afull_n)
  );

  logic [8:0] mq[$];
  logic [8:0] qexp;
  int wc, wc1, wc2, rc, rc1, rc2, ae, af;
  bit ldm, wsel, rsel, done;
  int vec = 0, errs = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int occw, occr;
    occw = wc - rc2;
    occr = wc2 - rc;
    chk("R3/R5 full_n", {31'b0, full_n}, 32'(occw != DEPTH));
    chk("R4/R5 empty_n", {31'b0, empty_n}, 32'(occr != 0));
    chk("R6 aempty_n", {31'b0, aempty_n}, 32'(!(occr <= ae)));
    chk("R7 afull_n", {31'b0, afull_n}, 32'(!((DEPTH - occw) <= af)));
    if (oe_n) chk("R12 bus released", {23'b0, qbus}, {23'b0, tb_val});
    else      chk("R1/R2/R10 q_out", {23'b0, qbus}, {23'b0, qexp});
  endtask

  task automatic step(input bit w1, input bit w2, input bit r1, input bit r2,
                      input logic [8:0] dv, input bit oe);
    bit fn, en, dw, ow, dr, orr;
    check_all();
    we1_n = w1; we2_ld = w2; re1_n = r1; re2_n = r2; d_in = dv;
    oe_n = oe; tb_en = oe; tb_val = 9'h15A;
    fn  = (wc - rc2) != DEPTH;
    en  = (wc2 - rc) != 0;
    dw  = !w1 && w2 && fn;
    ow  = ldm && !w1 && !w2;
    dr  = !r1 && !r2 && !(ldm && !w2) && en;
    orr = ldm && !r1 && !r2 && !w2;
    if (dr) qexp = mq.pop_front();
    if (orr) begin
      qexp = 9'(rsel ? af : ae);
      rsel = ~rsel;
    end
    if (dw) mq.push_back(dv);
    if (ow) begin
      if (wsel) af = int'(dv[4:0]);
      else      ae = int'(dv[4:0]);
      wsel = ~wsel;
    end
    wc2 = wc1; wc1 = wc; wc += int'(dw);
    rc2 = rc1; rc1 = rc; rc += int'(dr);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit load_mode);
    @(negedge clk);
    rst_n = 1'b0; we2_ld = !load_mode; we1_n = 1'b1; re1_n = 1'b1; re2_n = 1'b1;
    oe_n = 1'b0; tb_en = 1'b0; d_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mq.delete();
    wc = 0; wc1 = 0; wc2 = 0; rc = 0; rc1 = 0; rc2 = 0;
    ae = 2; af = 2; wsel = 0; rsel = 0; qexp = '0; ldm = load_mode;
    chk("R11 empty after reset", {31'b0, empty_n}, 0);
    chk("R11 aempty after reset", {31'b0, aempty_n}, 0);
    chk("R11 not full after reset", {31'b0, full_n}, 1);
    chk("R11 not afull after reset", {31'b0, afull_n}, 1);
    chk("R11 q cleared", {23'b0, qbus}, 0);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      bit wh, w1, w2, r1, r2, oe;
      int pw, pr;
      wh = ((i / 50) % 2) == 0;
      pw = wh ? 80 : 25;
      pr = wh ? 25 : 80;
      w1 = ($urandom % 100) >= pw;
      w2 = ldm ? (($urandom % 100) >= 5) : (($urandom % 100) >= 10);
      r1 = ($urandom % 100) >= pr;
      r2 = (($urandom % 20) == 0) ? ~r1 : r1;
      oe = ($urandom % 10) == 0;
      step(w1, w2, r1, r2, 9'($urandom % 512), oe);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b1; we1_n = 1'b1; we2_ld = 1'b1; re1_n = 1'b1; re2_n = 1'b1;
    oe_n = 1'b0; tb_en = 1'b0; tb_val = 9'h15A; d_in = '0;

    do_reset(1'b0);
    repeat (4) step(0, 0, 1, 1, 9'h1FF, 0);
    repeat (3) step(1, 1, 1, 1, 9'h0, 0);
    chk("R8 second enable low blocks write", {31'b0, empty_n}, 0);
    chk("R8 thresholds untouched", {31'b0, aempty_n}, 0);
    for (int i = 0; i < 20; i++) step(0, 1, 1, 1, 9'(i * 37 + 5), 0);
    repeat (2) step(1, 1, 1, 1, 9'h0, 0);
    chk("R3 full reached", {31'b0, full_n}, 0);
    chk("R7 afull at full", {31'b0, afull_n}, 0);
    for (int i = 0; i < 20; i++) step(1, 1, 0, 0, 9'h0, 0);
    repeat (3) step(1, 1, 1, 1, 9'h0, 0);
    chk("R4 empty after drain", {31'b0, empty_n}, 0);
    chk("R6 aempty after drain", {31'b0, aempty_n}, 0);
    step(1, 1, 1, 1, 9'h0, 1);
    chk("R12 released when oe_n high", {23'b0, qbus}, 32'h15A);
    random_run(3000);

    do_reset(1'b1);
    step(1, 0, 0, 0, 9'h0, 0);
    chk("R10 default almost-empty readback", {23'b0, qbus}, 2);
    step(1, 0, 0, 0, 9'h0, 0);
    chk("R10 default almost-full readback", {23'b0, qbus}, 2);
    repeat (2) step(1, 0, 0, 0, 9'h0, 0);
    step(0, 0, 1, 1, 9'h1E5, 0);
    step(0, 0, 1, 1, 9'h003, 0);
    step(1, 0, 0, 0, 9'h0, 0);
    chk("R9 almost-empty threshold loaded", {23'b0, qbus}, 5);
    step(1, 0, 0, 0, 9'h0, 0);
    chk("R9 almost-full threshold loaded", {23'b0, qbus}, 3);
    chk("R9 no data stored by loads", {31'b0, empty_n}, 0);
    repeat (4) step(0, 1, 1, 1, 9'h0AA, 0);
    repeat (2) step(1, 1, 1, 1, 9'h0, 0);
    step(1, 0, 0, 0, 9'h0, 0);
    step(1, 1, 1, 1, 9'h0, 0);
    chk("R10 offset read pops nothing", {31'b0, aempty_n}, 0);
    chk("R10 still not empty", {31'b0, empty_n}, 1);
    random_run(3000);

    check_all();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end
endmodule